// File: doc/BRIEF.md
# ADC Register Stub

This block is a word-wide, memory-mapped stand-in for a regular-channel analog-to-digital converter. It holds the converter's status, control, sample-time, threshold, sequence, injected-offset and injected-data registers. It does not sample anything real. When software starts a conversion and then reads the data word, the block steps an internal counter by a fixed increment and returns that counter as the sample. The sample is trimmed to the resolution that software selected and can be moved into a left-justified position.

Register access uses plain strobes rather than a stream handshake. An access is accepted in the cycle its strobe is high. The block never stalls, so there is no back-pressure. Read data is registered and appears the cycle after the read strobe. The address is a byte address over a 0x100-byte window, and only whole 32-bit words are decoded. The interrupt pin exists for pin compatibility and is never asserted.

Top module: `adc_regstub`

## Requirements
- R1: After reset every word reads 0, except the high-threshold word at 0x24, which reads 0x0000_0FFF.
- R2: A write to the status word at 0x00 can only clear bits: the new value is old & (wdata & 0x3F). Since no bit is ever set, it always reads 0.
- R3: Control word 1 (0x04), the sample-time words (0x0C, 0x10), the thresholds (0x24, 0x28), the sequence words (0x2C, 0x30, 0x34, 0x38) and control word 2 (0x08) store the full 32-bit write. A read of control word 2 returns bits 31:28 as zero.
- R4: A read of the data word (0x4C) with control-2 bit 0 (enable) and bit 30 (start) both set does three things: it adds 7 to the sample counter, it returns the result, and it clears bit 30. A second read without a new start returns 0.
- R5: A data-word read with either the enable bit or the start bit clear returns 0 and leaves the counter unchanged.
- R6: The resolution is set by control-1 bits 25:24, with codes 0=12, 1=10, 2=8 and 3=6 bits. The counter is masked to that width after every increment, and the stored counter keeps the masked value.
- R7: With control-2 bit 11 set, the returned sample is (counter << 1) & 0xFFF0. With bit 11 clear, it is the counter itself.
- R8: The four injected-offset words at 0x14, 0x18, 0x1C and 0x20 keep only the low 12 bits of a write.
- R9: The four injected-data words at 0x3C, 0x40, 0x44 and 0x48 store 32 bits. A read of channel n returns data n minus offset n, modulo 2^32.
- R10: Reads of offsets above 0x4C, or of addresses not word-aligned, return 0. Writes to them, and writes to the data word, change nothing.
- R11: The interrupt output stays low.
- R12: The read-data output updates only in the cycle after a read strobe and otherwise holds its value.
- R13: When a read and a write of the same word occur in one cycle, the read returns the contents from before the write, and the write takes effect for later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data, valid the cycle after rd_en |
| irq | output | 1 | Interrupt, held low |

## Verification
A read and a write can land in the same cycle on the same word. When that word is the data word, the read side effects must still happen: the counter advances and the start bit clears. The bench raises both strobes together on the high-threshold word and on the data word. It checks that the first read returns the old threshold. It checks that a following read returns the new threshold. It also checks that the data-word read advanced the counter while the write to that word was dropped.

// File: rtl/adc_stub_pkg.sv
`timescale 1ns/1ps
package adc_stub_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int IDX_W  = ADDR_W - 2;
  typedef logic [IDX_W-1:0] widx_t;

  localparam int INJ_N = 4;
  localparam int NW    = 20;          // decoded words, 0x00..0x4C

  localparam widx_t IDX_SR    = 6'd0;
  localparam widx_t IDX_CR1   = 6'd1;
  localparam widx_t IDX_CR2   = 6'd2;
  localparam widx_t IDX_JOFR0 = 6'd5;
  localparam widx_t IDX_HTR   = 6'd9;
  localparam widx_t IDX_JDR0  = 6'd15;
  localparam widx_t IDX_DR    = 6'd19;

  localparam int EN_BIT    = 0;
  localparam int ALIGN_BIT = 11;
  localparam int START_BIT = 30;
  localparam int RES_LSB   = 24;

  localparam logic [DATA_W-1:0] SR_WMASK  = 32'h0000_003F;
  localparam logic [DATA_W-1:0] CR2_RMASK = 32'h0FFF_FFFF;
  localparam logic [DATA_W-1:0] HTR_RST   = 32'h0000_0FFF;

  localparam int SMP_W = 12;          // widest resolution
  localparam int OFS_W = 12;
  localparam int OUT_W = 16;

  function automatic logic [SMP_W-1:0] res_mask(input logic [1:0] code);
    case (code)
      2'd0:    return 12'hFFF;
      2'd1:    return 12'h3FF;
      2'd2:    return 12'h0FF;
      default: return 12'h03F;
    endcase
  endfunction

  // words that simply store a full write
  function automatic bit is_plain(input int i);
    return (i == 1) || (i == 3) || (i == 4) || ((i >= 9) && (i <= 14));
  endfunction
endpackage

// File: rtl/adc_ctrl_bank.sv
`timescale 1ns/1ps
module adc_ctrl_bank
  import adc_stub_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  widx_t             wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start_clr,
  output logic [DATA_W-1:0] word_q [NW]
);
  for (genvar i = 0; i < NW; i++) begin : g_word
    localparam widx_t ME = widx_t'(i);
    if (i == int'(IDX_SR)) begin : g_sr
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        q <= '0;
        else if (wr_en && wr_idx == ME)    q <= q & (wr_data & SR_WMASK);
      end
      assign word_q[i] = q;
    end else if (i == int'(IDX_CR2)) begin : g_cr2
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        q <= '0;
        else if (wr_en && wr_idx == ME)    q <= wr_data;   // write wins
        else if (start_clr)                q[START_BIT] <= 1'b0;
      end
      assign word_q[i] = q;
    end else if (is_plain(i)) begin : g_plain
      localparam logic [DATA_W-1:0] RST = (i == int'(IDX_HTR)) ? HTR_RST : '0;
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        q <= RST;
        else if (wr_en && wr_idx == ME)    q <= wr_data;
      end
      assign word_q[i] = q;
    end else begin : g_none
      assign word_q[i] = '0;
    end
  end
endmodule

// File: rtl/adc_inj_bank.sv
`timescale 1ns/1ps
module adc_inj_bank
  import adc_stub_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  widx_t             wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ofs_rd [INJ_N],
  output logic [DATA_W-1:0] diff_rd [INJ_N]
);
  for (genvar k = 0; k < INJ_N; k++) begin : g_ch
    localparam widx_t OFS_IDX = widx_t'(int'(IDX_JOFR0) + k);
    localparam widx_t DAT_IDX = widx_t'(int'(IDX_JDR0) + k);
    logic [OFS_W-1:0]  ofs_q;
    logic [DATA_W-1:0] dat_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ofs_q <= '0;
        dat_q <= '0;
      end else if (wr_en) begin
        if (wr_idx == OFS_IDX) ofs_q <= wr_data[OFS_W-1:0];
        if (wr_idx == DAT_IDX) dat_q <= wr_data;
      end
    end
    assign ofs_rd[k]  = {{(DATA_W-OFS_W){1'b0}}, ofs_q};
    assign diff_rd[k] = dat_q - ofs_rd[k];
  end
endmodule

// File: rtl/adc_sample_gen.sv
`timescale 1ns/1ps
module adc_sample_gen
  import adc_stub_pkg::*;
#(
  parameter int STEP = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [1:0]       res,
  input  logic             align,
  output logic [OUT_W-1:0] sample
);
  logic [SMP_W-1:0] cnt_q, nxt;

  assign nxt = (cnt_q + SMP_W'(STEP)) & res_mask(res);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (fire) cnt_q <= nxt;
  end

  always_comb begin
    if (align) sample = {{(OUT_W-SMP_W-1){1'b0}}, nxt, 1'b0} & 16'hFFF0;
    else       sample = {{(OUT_W-SMP_W){1'b0}}, nxt};
  end
endmodule

// File: rtl/adc_regstub.sv
`timescale 1ns/1ps
module adc_regstub
  import adc_stub_pkg::*;
#(
  parameter int STEP = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  widx_t             idx;
  logic              word_ok, wr_ok, fire;
  logic [DATA_W-1:0] word_q  [NW];
  logic [DATA_W-1:0] ofs_rd  [INJ_N];
  logic [DATA_W-1:0] diff_rd [INJ_N];
  logic [OUT_W-1:0]  sample;
  logic [DATA_W-1:0] cr1, cr2, rd_word;

  assign idx     = addr[ADDR_W-1:2];
  assign word_ok = (addr[1:0] == 2'b00);
  assign wr_ok   = wr_en && word_ok;
  assign cr1     = word_q[IDX_CR1];
  assign cr2     = word_q[IDX_CR2];
  assign fire    = rd_en && word_ok && (idx == IDX_DR) && cr2[EN_BIT] && cr2[START_BIT];
  assign irq     = 1'b0;

  adc_ctrl_bank u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .wr_idx(idx),
    .wr_data(wr_data), .start_clr(fire), .word_q(word_q)
  );

  adc_inj_bank u_inj (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .wr_idx(idx),
    .wr_data(wr_data), .ofs_rd(ofs_rd), .diff_rd(diff_rd)
  );

  adc_sample_gen #(.STEP(STEP)) u_gen (
    .clk(clk), .rst_n(rst_n), .fire(fire),
    .res(cr1[RES_LSB+1:RES_LSB]), .align(cr2[ALIGN_BIT]), .sample(sample)
  );

  always_comb begin
    rd_word = '0;
    if (word_ok && idx < widx_t'(NW)) begin
      rd_word = word_q[idx];
      if (idx == IDX_CR2) rd_word = cr2 & CR2_RMASK;
      if (idx == IDX_DR)  rd_word = fire ? {{(DATA_W-OUT_W){1'b0}}, sample} : '0;
      for (int k = 0; k < INJ_N; k++) begin
        if (idx == widx_t'(int'(IDX_JOFR0) + k)) rd_word = ofs_rd[k];
        if (idx == widx_t'(int'(IDX_JDR0) + k))  rd_word = diff_rd[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_word;
  end
endmodule

// File: rtl/adc_regstub_chk.sv
`timescale 1ns/1ps
module adc_regstub_chk
  import adc_stub_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq
);
  localparam logic [ADDR_W-1:0] A_SR  = {IDX_SR, 2'b00};
  localparam logic [ADDR_W-1:0] A_CR2 = {IDX_CR2, 2'b00};
  localparam logic [ADDR_W-1:0] A_DR  = {IDX_DR, 2'b00};

  logic unmapped;
  assign unmapped = (addr[1:0] != 2'b00) || (addr[ADDR_W-1:2] >= widx_t'(NW));

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));                                      // R12
  AST_CR2_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_CR2) |=> (rd_data[31:28] == 4'h0));            // R3
  AST_SR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_SR) |=> (rd_data == '0));                      // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unmapped) |=> (rd_data == '0));                          // R10
  AST_SAMPLE_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_DR) |=> (rd_data[31:16] == 16'h0));            // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !irq);                                                   // R11
endmodule

bind adc_regstub adc_regstub_chk chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en),
  .rd_data(rd_data), .irq(irq)
);

// File: tb/adc_regstub_tb_top.sv
`timescale 1ns/1ps
module adc_regstub_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;
  int          nvec = 0, nbad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  adc_regstub dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  a;
    logic [31:0] d;     // write data, or expected read data
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VT [NV] = '{
    '{1'b1, 8'h04, 32'h0000_0000, 4'd0},
    '{1'b0, 8'h4C, 32'h0000_0000, 4'd5},   // R5 not enabled
    '{1'b1, 8'h08, 32'h4000_0001, 4'd0},
    '{1'b0, 8'h4C, 32'h0000_0007, 4'd4},   // R4 first sample
    '{1'b0, 8'h4C, 32'h0000_0000, 4'd4},   // R4 start cleared
    '{1'b0, 8'h08, 32'h0000_0001, 4'd3},   // R3 top nibble hidden
    '{1'b1, 8'h08, 32'h4000_0001, 4'd0},
    '{1'b0, 8'h4C, 32'h0000_000E, 4'd4},
    '{1'b1, 8'h04, 32'h0300_0000, 4'd0},
    '{1'b1, 8'h08, 32'h4000_0801, 4'd0},
    '{1'b0, 8'h4C, 32'h0000_0020, 4'd7},   // R7 21 aligned
    '{1'b1, 8'h14, 32'hFFFF_F123, 4'd0},
    '{1'b0, 8'h14, 32'h0000_0123, 4'd8},   // R8
    '{1'b1, 8'h3C, 32'h0000_0100, 4'd0},
    '{1'b0, 8'h3C, 32'hFFFF_FFDD, 4'd9},   // R9 wraps
    '{1'b1, 8'h20, 32'h0000_0005, 4'd0},
    '{1'b1, 8'h48, 32'h0000_0003, 4'd0},
    '{1'b0, 8'h48, 32'hFFFF_FFFE, 4'd9},
    '{1'b1, 8'h24, 32'hDEAD_BEEF, 4'd0},
    '{1'b0, 8'h24, 32'hDEAD_BEEF, 4'd3},
    '{1'b1, 8'h00, 32'hFFFF_FFFF, 4'd0},
    '{1'b0, 8'h00, 32'h0000_0000, 4'd2},   // R2
    '{1'b1, 8'h50, 32'h0000_1234, 4'd0},
    '{1'b0, 8'h50, 32'h0000_0000, 4'd10},  // R10
    '{1'b1, 8'h4C, 32'h0000_0055, 4'd0},
    '{1'b1, 8'h04, 32'h0000_0000, 4'd0},
    '{1'b1, 8'h08, 32'h4000_0001, 4'd0},
    '{1'b0, 8'h4C, 32'h0000_001C, 4'd10},  // R10 DR write ignored
    '{1'b0, 8'h06, 32'h0000_0000, 4'd10},
    '{1'b0, 8'h08, 32'h0000_0001, 4'd3}
  };

  task automatic check(input int rq, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL R%0d: got %08h expected %08h", rq, got, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic do_rw(input logic [7:0] a, input logic [31:0] d, output logic [31:0] v);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0; v = rd_data;
  endtask

  function automatic logic [11:0] mask_of(input int r);
    case (r)
      0: return 12'hFFF;
      1: return 12'h3FF;
      2: return 12'h0FF;
      default: return 12'h03F;
    endcase
  endfunction

  initial begin
    logic [31:0] v, held;
    logic [11:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    do_rd(8'h24, v); check(1, v, 32'h0000_0FFF);
    do_rd(8'h04, v); check(1, v, 32'h0);
    do_rd(8'h08, v); check(1, v, 32'h0);
    do_rd(8'h3C, v); check(1, v, 32'h0);
    do_rd(8'h14, v); check(1, v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VT[i].wr) do_wr(VT[i].a, VT[i].d);
      else begin do_rd(VT[i].a, v); check(int'(VT[i].rq), v, VT[i].d); end
    end
    m = 12'h01C;

    // R5 start without enable
    do_wr(8'h08, 32'h4000_0000);
    do_rd(8'h4C, v); check(5, v, 32'h0);
    do_wr(8'h08, 32'h4000_0001);
    m = m + 12'd7;
    do_rd(8'h4C, v); check(5, v, {20'h0, m});

    // R6 every resolution, including wrap
    for (int r = 0; r < 4; r++) begin
      do_wr(8'h04, 32'(r) << 24);
      for (int k = 0; k < 10; k++) begin
        do_wr(8'h08, 32'h4000_0001);
        m = (m + 12'd7) & mask_of(r);
        do_rd(8'h4C, v); check(6, v, {20'h0, m});
      end
    end

    // R7 alignment at 8 bits
    do_wr(8'h04, 32'h0200_0000);
    do_wr(8'h08, 32'h4000_0801);
    m = (m + 12'd7) & 12'h0FF;
    do_rd(8'h4C, v); check(7, v, {19'h0, m, 1'b0} & 32'h0000_FFF0);

    // R13 read and write of one word together
    do_rw(8'h24, 32'h0BAD_F00D, v); check(13, v, 32'hDEAD_BEEF);
    do_rd(8'h24, v); check(13, v, 32'h0BAD_F00D);
    do_wr(8'h08, 32'h4000_0001);
    m = (m + 12'd7) & 12'h0FF;
    do_rw(8'h4C, 32'h0000_FFFF, v); check(13, v, {20'h0, m});
    do_rd(8'h4C, v); check(13, v, 32'h0);

    // R12 hold without strobe
    do_rd(8'h24, held);
    addr = 8'h04;
    repeat (3) @(negedge clk);
    check(12, rd_data, held);

    // R11 interrupt quiet
    check(11, {31'h0, irq}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule